// File: doc/BRIEF.md
# DDR2 Burst Latency Scheduler

This block sits between a memory controller's command path and its data-path PHY. It accepts read and write commands that have already been decoded, each with the low bits of its starting column. It works out when the data for each command appears on the bus and drives the cycle-level enables for that window. Commands are posted: the block accepts them at once and holds them inside for the programmed additive latency plus CAS latency. Writes come out one clock earlier than reads.

Each command opens a data window of half the burst length in clock cycles, because two beats move per clock. During the window the block gives the index of the current clock within the burst and the column addresses of the beat on the rising edge and the beat on the falling edge. It follows the programmed wrap order, sequential or interleaved. A second command placed exactly one burst behind the first carries the window on with no idle cycle. The write strobe enable trails the write drive enable by half a clock, so the strobe can sit centred in the write data. Latency settings out of range are clamped to the nearest legal value and flagged.

Top module: `ddr2_burst_sched`

## Requirements
- R1: A read sampled at rising edge 0 asserts `rd_capture_en` from rising edge AL+CL. AL and CL are the clamped additive and CAS latencies, and edge n means the cycle that edge n starts.
- R2: A write sampled at edge 0 asserts `wr_drive_en` from edge AL+CL-1, one clock earlier than a read with the same settings.
- R3: A window lasts 4 cycles when `cfg_burst8`=1 (burst of 8) and 2 cycles when it is 0 (burst of 4). `beat_idx` counts 0,1,.. through the window. Outside any window `beat_idx`, `beat_col_rise` and `beat_col_fall` are 0.
- R4: With `cfg_interleave`=0, burst position p has column (s mod B + p) mod B plus (s minus s mod B). Here s is `cmd_col` and B is the burst length. Clock k of the window carries positions 2k on `beat_col_rise` and 2k+1 on `beat_col_fall`.
- R5: With `cfg_interleave`=1, position p has column s XOR p, and the rise/fall split is the same as in R4.
- R6: A command whose window begins in the cycle right after the previous window ends continues the data window with no idle cycle, and `beat_idx` restarts at 0. This holds read after read, write after write and read after write.
- R7: A `cfg_cas_lat` below 3 is used as 3 and one above 7 is used as 7. In either case `cfg_err` is 1. It is 0 when both latencies are legal.
- R8: A `cfg_add_lat` above 6 is used as 6, and `cfg_err` is 1.
- R9: `wr_strobe_en` follows `wr_drive_en` at the next falling clock edge, half a clock after the data enable changes.
- R10: While `rst_n` is low all enables, `beat_idx` and both column outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 3 | Starting column low bits |
| cfg_cas_lat | input | CFG_W | CAS latency setting in clocks |
| cfg_add_lat | input | CFG_W | Additive latency setting in clocks |
| cfg_burst8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cfg_interleave | input | 1 | 1 = interleaved wrap order, 0 = sequential |
| rd_capture_en | output | 1 | Read data window active |
| wr_drive_en | output | 1 | Write data window active |
| wr_strobe_en | output | 1 | Write strobe enable, updated on the falling edge |
| beat_idx | output | 2 | Clock index within the current burst |
| beat_col_rise | output | 3 | Column of the rising-edge beat |
| beat_col_fall | output | 3 | Column of the falling-edge beat |
| cfg_err | output | 1 | A latency setting was out of range and clamped |

## Verification
The bench builds the block with its default parameters. These are a 4-bit setting width, CAS latency 3 to 7 and additive latency up to 6, which gives a delay line of 13 stages. Every stage can therefore be reached, from the shortest write latency of 2 to the longest read latency of 13. The 4-bit setting width also lets the bench drive values below and above the legal ranges, which brings both clamp directions and the error flag within reach. Both burst lengths and both wrap orders are run from unaligned start columns. Back-to-back pairs are placed exactly one burst apart, including a read followed by a write.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;

   localparam int unsigned MAX_BL = 8;
   localparam int unsigned COL_W  = $clog2(MAX_BL);
   localparam int unsigned CYC_W  = $clog2(MAX_BL / 2);

   typedef struct packed {
      logic             vld;
      logic             wr;
      logic             bl8;
      logic             ilv;
      logic [COL_W-1:0] col;
   } burst_tok_t;

   // column of burst position pos for a burst that starts at column start
   function automatic logic [COL_W-1:0] order_col(input logic [COL_W-1:0] start,
                                                  input logic [COL_W-1:0] pos,
                                                  input logic             bl8,
                                                  input logic             ilv);
      logic [COL_W-1:0] mask;
      logic [COL_W-1:0] sum;
      mask = bl8 ? {COL_W{1'b1}} : {1'b0, {(COL_W-1){1'b1}}};
      sum  = start + pos;
      if (ilv) return start ^ (pos & mask);
      return (start & ~mask) | (sum & mask);
   endfunction

endpackage

// File: rtl/ddr2_lat_cfg.sv
module ddr2_lat_cfg #(
   parameter int unsigned CFG_W  = 4,
   parameter int unsigned CL_MIN = 3,
   parameter int unsigned CL_MAX = 7,
   parameter int unsigned AL_MAX = 6,
   parameter int unsigned LAT_W  = 4
) (
   input  logic [CFG_W-1:0] cfg_cl,
   input  logic [CFG_W-1:0] cfg_al,
   output logic [LAT_W-1:0] rd_lat,
   output logic [LAT_W-1:0] wr_lat,
   output logic             cfg_err
);

   logic             cl_lo, cl_hi, al_hi;
   logic [CFG_W-1:0] cl_c, al_c;

   always_comb begin
      cl_lo = cfg_cl < CFG_W'(CL_MIN);
      cl_hi = cfg_cl > CFG_W'(CL_MAX);
      al_hi = cfg_al > CFG_W'(AL_MAX);
      cl_c  = cl_lo ? CFG_W'(CL_MIN) : (cl_hi ? CFG_W'(CL_MAX) : cfg_cl);
      al_c  = al_hi ? CFG_W'(AL_MAX) : cfg_al;
   end

   assign rd_lat  = LAT_W'(cl_c) + LAT_W'(al_c);
   assign wr_lat  = rd_lat - LAT_W'(1);
   assign cfg_err = cl_lo | cl_hi | al_hi;

endmodule

// File: rtl/ddr2_lat_pipe.sv
module ddr2_lat_pipe
   import ddr2_sched_pkg::*;
#(
   parameter int unsigned DEPTH = 13,
   parameter int unsigned LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  burst_tok_t       inj_tok,
   input  logic [LAT_W-1:0] inj_lat,
   output burst_tok_t       head
);

   burst_tok_t stage_q [DEPTH];
   burst_tok_t stage_d [DEPTH];

   if (DEPTH < 1) begin : g_bad_depth
      $error("ddr2_lat_pipe: DEPTH must be at least 1");
   end

   // slot i holds a token that starts its burst i+1 edges from now
   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      burst_tok_t upstream;
      if (i == DEPTH - 1) begin : g_tail
         assign upstream = '0;
      end else begin : g_body
         assign upstream = stage_q[i+1];
      end
      assign stage_d[i] = (inj_tok.vld && inj_lat == LAT_W'(i + 1)) ? inj_tok : upstream;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n) stage_q[i] <= '0;
         else        stage_q[i] <= stage_d[i];
      end
   end

   assign head = stage_q[0];

endmodule

// File: rtl/ddr2_burst_gen.sv
module ddr2_burst_gen
   import ddr2_sched_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  burst_tok_t       start,
   output logic             rd_en,
   output logic             wr_en,
   output logic             wr_strb,
   output logic [CYC_W-1:0] cyc_idx,
   output logic [COL_W-1:0] col_rise,
   output logic [COL_W-1:0] col_fall
);

   logic             act_q;
   burst_tok_t       cur_q;
   logic [CYC_W-1:0] cyc_q;
   logic [CYC_W-1:0] last_cyc;

   assign last_cyc = cur_q.bl8 ? CYC_W'(MAX_BL / 2 - 1) : CYC_W'(MAX_BL / 4 - 1);

   // a starting token wins over the running burst, which gives gapless chaining
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cur_q <= '0;
         cyc_q <= '0;
      end else if (start.vld) begin
         act_q <= 1'b1;
         cur_q <= start;
         cyc_q <= '0;
      end else if (act_q) begin
         if (cyc_q == last_cyc) act_q <= 1'b0;
         else                   cyc_q <= cyc_q + CYC_W'(1);
      end
   end

   // half-clock offset: strobe enable changes on the falling edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) wr_strb <= 1'b0;
      else        wr_strb <= act_q & cur_q.wr;
   end

   assign rd_en    = act_q & ~cur_q.wr;
   assign wr_en    = act_q &  cur_q.wr;
   assign cyc_idx  = act_q ? cyc_q : '0;
   assign col_rise = act_q ? order_col(cur_q.col, COL_W'({cyc_q, 1'b0}), cur_q.bl8, cur_q.ilv) : '0;
   assign col_fall = act_q ? order_col(cur_q.col, COL_W'({cyc_q, 1'b1}), cur_q.bl8, cur_q.ilv) : '0;

endmodule

// File: rtl/ddr2_burst_sched.sv
module ddr2_burst_sched
   import ddr2_sched_pkg::*;
#(
   parameter int unsigned CFG_W  = 4,
   parameter int unsigned CL_MIN = 3,
   parameter int unsigned CL_MAX = 7,
   parameter int unsigned AL_MAX = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [COL_W-1:0] cmd_col,
   input  logic [CFG_W-1:0] cfg_cas_lat,
   input  logic [CFG_W-1:0] cfg_add_lat,
   input  logic             cfg_burst8,
   input  logic             cfg_interleave,
   output logic             rd_capture_en,
   output logic             wr_drive_en,
   output logic             wr_strobe_en,
   output logic [CYC_W-1:0] beat_idx,
   output logic [COL_W-1:0] beat_col_rise,
   output logic [COL_W-1:0] beat_col_fall,
   output logic             cfg_err
);

   localparam int unsigned DEPTH = AL_MAX + CL_MAX;
   localparam int unsigned LAT_W = $clog2(DEPTH + 1);

   if (CL_MIN < 2) begin : g_bad_clmin
      $error("ddr2_burst_sched: CL_MIN must be at least 2 so write latency stays above 0");
   end
   if (CL_MAX < CL_MIN) begin : g_bad_clrange
      $error("ddr2_burst_sched: CL_MAX below CL_MIN");
   end
   if ((CL_MAX >= (1 << CFG_W)) || (AL_MAX >= (1 << CFG_W))) begin : g_bad_cfgw
      $error("ddr2_burst_sched: CFG_W too narrow for the latency range");
   end

   logic [LAT_W-1:0] rd_lat, wr_lat;
   burst_tok_t       inj_tok, head;

   ddr2_lat_cfg #(
      .CFG_W (CFG_W),
      .CL_MIN(CL_MIN),
      .CL_MAX(CL_MAX),
      .AL_MAX(AL_MAX),
      .LAT_W (LAT_W)
   ) u_cfg (
      .cfg_cl (cfg_cas_lat),
      .cfg_al (cfg_add_lat),
      .rd_lat (rd_lat),
      .wr_lat (wr_lat),
      .cfg_err(cfg_err)
   );

   assign inj_tok = '{vld: cmd_valid, wr: cmd_write, bl8: cfg_burst8,
                      ilv: cfg_interleave, col: cmd_col};

   ddr2_lat_pipe #(
      .DEPTH(DEPTH),
      .LAT_W(LAT_W)
   ) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .inj_tok(inj_tok),
      .inj_lat(cmd_write ? wr_lat : rd_lat),
      .head   (head)
   );

   ddr2_burst_gen u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (head),
      .rd_en   (rd_capture_en),
      .wr_en   (wr_drive_en),
      .wr_strb (wr_strobe_en),
      .cyc_idx (beat_idx),
      .col_rise(beat_col_rise),
      .col_fall(beat_col_fall)
   );

endmodule

// File: rtl/ddr2_burst_sched_chk.sv
module ddr2_burst_sched_chk #(
   parameter int unsigned CFG_W  = 4,
   parameter int unsigned CL_MIN = 3,
   parameter int unsigned CL_MAX = 7,
   parameter int unsigned AL_MAX = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_write,
   input logic [CFG_W-1:0] cfg_cas_lat,
   input logic [CFG_W-1:0] cfg_add_lat,
   input logic             cfg_err,
   input logic             rd_capture_en,
   input logic             wr_drive_en,
   input logic             wr_strobe_en,
   input logic [1:0]       beat_idx
);

   logic any_en;
   assign any_en = rd_capture_en | wr_drive_en;

   // R1: shortest read latency, 3 clocks
   p_rd_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_write && cfg_cas_lat == CFG_W'(3) && cfg_add_lat == CFG_W'(0))
      |-> ##4 rd_capture_en);

   // R2: write one clock earlier
   p_wr_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && cfg_cas_lat == CFG_W'(3) && cfg_add_lat == CFG_W'(0))
      |-> ##3 wr_drive_en);

   p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_en) |-> beat_idx == 2'd0);

   p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (any_en && $past(any_en) && beat_idx != 2'd0) |-> beat_idx == 2'($past(beat_idx) + 2'd1));

   p_legal_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cas_lat >= CFG_W'(CL_MIN) && cfg_cas_lat <= CFG_W'(CL_MAX) &&
       cfg_add_lat <= CFG_W'(AL_MAX)) |-> !cfg_err);

   p_strobe_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_en == wr_drive_en);

endmodule

bind ddr2_burst_sched ddr2_burst_sched_chk #(
   .CFG_W (CFG_W),
   .CL_MIN(CL_MIN),
   .CL_MAX(CL_MAX),
   .AL_MAX(AL_MAX)
) u_chk (.*);

// File: tb/tb_ddr2_burst_sched.sv
module tb_ddr2_burst_sched;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_write = 1'b0;
   logic [2:0] cmd_col = '0;
   logic [3:0] cfg_cas_lat = 4'd3;
   logic [3:0] cfg_add_lat = 4'd0;
   logic       cfg_burst8 = 1'b1;
   logic       cfg_interleave = 1'b0;
   logic       rd_capture_en, wr_drive_en, wr_strobe_en, cfg_err;
   logic [1:0] beat_idx;
   logic [2:0] beat_col_rise, beat_col_fall;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ddr2_burst_sched dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_col(cmd_col), .cfg_cas_lat(cfg_cas_lat), .cfg_add_lat(cfg_add_lat),
      .cfg_burst8(cfg_burst8), .cfg_interleave(cfg_interleave),
      .rd_capture_en(rd_capture_en), .wr_drive_en(wr_drive_en),
      .wr_strobe_en(wr_strobe_en), .beat_idx(beat_idx),
      .beat_col_rise(beat_col_rise), .beat_col_fall(beat_col_fall), .cfg_err(cfg_err)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_col(int s, int p, bit bl8, bit ilv);
      int b = bl8 ? 8 : 4;
      int lo = s % b;
      if (ilv) return s ^ p;
      return (s - lo) + ((lo + p) % b);
   endfunction

   task automatic set_cfg(int cl, int al, bit bl8, bit ilv);
      @(negedge clk);
      #2;
      cfg_cas_lat    = 4'(cl);
      cfg_add_lat    = 4'(al);
      cfg_burst8     = bl8;
      cfg_interleave = ilv;
      #1;
   endtask

   // one or two commands; second issued gap edges after the first
   task automatic run_case(string req, int cl_e, int al_e, bit w1, int col1,
                           bit has2, int gap, bit w2, int col2);
      int n = cfg_burst8 ? 4 : 2;
      int l1 = al_e + cl_e - (w1 ? 1 : 0);
      int l2 = al_e + cl_e - (w2 ? 1 : 0);
      int last = l1 + n;
      int prev_wr = 0;
      if (has2 && gap + l2 + n > last) last = gap + l2 + n;
      for (int k = 0; k <= last + 1; k++) begin
         int e_rd, e_wr, e_idx, e_cr, e_cf, j, s;
         bit w, in_win;
         @(negedge clk);
         #2;
         chk(req, "R9 strobe after falling edge", int'(wr_strobe_en), prev_wr);
         cmd_valid = (k == 0) || (has2 && k == gap);
         cmd_write = (has2 && k == gap) ? w2 : w1;
         cmd_col   = (has2 && k == gap) ? 3'(col2) : 3'(col1);
         @(posedge clk);
         #2;
         in_win = 1'b0; w = 1'b0; j = 0; s = 0;
         if (has2 && k >= gap + l2 && k < gap + l2 + n) begin
            in_win = 1'b1; w = w2; j = k - gap - l2; s = col2;
         end else if (k >= l1 && k < l1 + n) begin
            in_win = 1'b1; w = w1; j = k - l1; s = col1;
         end
         e_rd  = (in_win && !w) ? 1 : 0;
         e_wr  = (in_win && w) ? 1 : 0;
         e_idx = in_win ? j : 0;
         e_cr  = in_win ? exp_col(s, 2 * j, cfg_burst8, cfg_interleave) : 0;
         e_cf  = in_win ? exp_col(s, 2 * j + 1, cfg_burst8, cfg_interleave) : 0;
         chk(req, "rd_capture_en", int'(rd_capture_en), e_rd);
         chk(req, "wr_drive_en", int'(wr_drive_en), e_wr);
         chk(req, "beat_idx", int'(beat_idx), e_idx);
         chk(req, "beat_col_rise", int'(beat_col_rise), e_cr);
         chk(req, "beat_col_fall", int'(beat_col_fall), e_cf);
         chk(req, "R9 strobe still old at rising edge", int'(wr_strobe_en), prev_wr);
         prev_wr = e_wr;
      end
      cmd_valid = 1'b0;
   endtask

   task automatic test_reset();
      repeat (3) @(posedge clk);
      #2;
      chk("R10", "rd_capture_en", int'(rd_capture_en), 0);
      chk("R10", "wr_drive_en", int'(wr_drive_en), 0);
      chk("R10", "wr_strobe_en", int'(wr_strobe_en), 0);
      chk("R10", "beat_idx", int'(beat_idx), 0);
      chk("R10", "beat_cols", int'({beat_col_rise, beat_col_fall}), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_basic_orders();
      set_cfg(3, 0, 1, 0);
      chk("R7", "cfg_err legal", int'(cfg_err), 0);
      run_case("R1 R3 R4 seq8", 3, 0, 1'b0, 5, 1'b0, 0, 1'b0, 0);
      set_cfg(5, 2, 0, 1);
      run_case("R2 R5 R9 ilv4", 5, 2, 1'b1, 3, 1'b0, 0, 1'b0, 0);
      set_cfg(7, 6, 1, 1);
      chk("R8", "cfg_err legal max", int'(cfg_err), 0);
      run_case("R1 R5 ilv8 longest", 7, 6, 1'b0, 5, 1'b0, 0, 1'b0, 0);
      set_cfg(4, 1, 1, 0);
      run_case("R2 R4 R9 seq8", 4, 1, 1'b1, 2, 1'b0, 0, 1'b0, 0);
      set_cfg(4, 0, 0, 0);
      run_case("R4 seq4 wrap", 4, 0, 1'b0, 6, 1'b0, 0, 1'b0, 0);
   endtask

   task automatic test_gapless();
      set_cfg(5, 0, 1, 0);
      run_case("R6 rd-rd", 5, 0, 1'b0, 0, 1'b1, 4, 1'b0, 6);
      set_cfg(3, 3, 0, 1);
      run_case("R6 R9 wr-wr", 3, 3, 1'b1, 1, 1'b1, 2, 1'b1, 7);
      set_cfg(3, 1, 0, 0);
      run_case("R6 rd-wr", 3, 1, 1'b0, 4, 1'b1, 3, 1'b1, 2);
   endtask

   task automatic test_clamp();
      set_cfg(1, 0, 1, 0);
      chk("R7", "cfg_err low CL", int'(cfg_err), 1);
      run_case("R7 CL low clamp", 3, 0, 1'b0, 1, 1'b0, 0, 1'b0, 0);
      set_cfg(12, 0, 1, 0);
      chk("R7", "cfg_err high CL", int'(cfg_err), 1);
      run_case("R7 CL high clamp", 7, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
      set_cfg(3, 9, 0, 0);
      chk("R8", "cfg_err high AL", int'(cfg_err), 1);
      run_case("R8 AL clamp", 3, 6, 1'b1, 2, 1'b0, 0, 1'b0, 0);
      set_cfg(3, 0, 1, 0);
      chk("R7", "cfg_err cleared", int'(cfg_err), 0);
   endtask

   initial begin
      test_reset();
      test_basic_orders();
      test_gapless();
      test_clamp();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule